// File: doc/BRIEF.md
# Asynchronous Strobe Bus Master Sequencer

This block is the master side of a 16-bit bus that has an address strobe, separate upper and lower data strobes, and a termination that arrives asynchronously from the slave. A request presents an address, a 3-bit function code, a direction, an access size (byte, word or long-word) and write data. The block then steps one bus cycle, or two for a long-word, through its half-clock states. It waits for the slave's acknowledge or bus-error line, latches read data, and reports completion with an optional error flag.

The block runs on a clock at twice the bus rate, so each bus state occupies exactly one block clock. The edge-specific events of the bus therefore become ordinary state transitions. The acknowledge and bus-error inputs are retimed by a two-flop synchronizer and are sampled only in state S4. A normal cycle runs through states S0 to S7. When neither termination is seen, whole bus clocks (two block clocks each) are inserted after S4. A termination by bus error alone stretches the cycle through S9 and ends it with an error.

Top module: `strobe_bus_master`

## Requirements
- R1: While reset is held, `bus_as`, `bus_uds`, `bus_lds`, `bus_doe` and `rsp_done` are 0, `bus_rw` is 1 and `req_ready` is 1.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. In the next cycle (S0), `bus_addr`, `bus_fc` and `bus_rw` (1 = read) show the request, and the strobes stay 0 through S0 and S1.
- R3: The address strobe and the selected data strobes (all active high) rise in S2, the third cycle of a bus cycle.
- R4: Acknowledge and bus error pass through two flops and are sampled in S4. If neither is seen, two wait cycles follow and S4 samples again.
- R5: If acknowledge is seen in S4, with or without bus error, S5 and S6 follow. At the edge entering S7, `bus_din` is latched and the strobes drop. `rsp_done` is 1 and `rsp_err` is 0 during S7 of the last word.
- R6: If bus error is seen in S4 without acknowledge, the strobes stay asserted for four more cycles (S5 to S8) and drop in S9. During S9, `rsp_done` and `rsp_err` are both 1.
- R7: Size code 00 is a byte access. If address bit 0 is 0, only `bus_uds` is used and `rsp_rdata` = {24'h0, din[15:8]}. If bit 0 is 1, only `bus_lds` is used and `rsp_rdata` = {24'h0, din[7:0]}. A byte write drives `req_wdata[7:0]` on both halves of `bus_dout`.
- R8: Size code 01 (and 11) is a word access. It asserts both data strobes, returns {16'h0, din} and writes `req_wdata[15:0]`.
- R9: Size code 10 is a long-word access, done as two word cycles in which S7 of the first leads straight into S0 of the second. The second cycle uses the address plus 2. The first word carries bits 31:16 and the second carries bits 15:0. `rsp_done` is raised only after the second word.
- R10: A bus-error termination on the first word of a long-word ends the request in S9 without a second cycle.
- R11: `bus_doe` is 1 only on writes, from S3 until the strobes drop: through S7 on the acknowledge path, and through S8 on the bus-error path.
- R12: `req_ready` is 0 from S0 until the request completes, and a `req_valid` seen in that time is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, twice the bus rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to accept |
| req_addr | input | AW | Byte address |
| req_fc | input | 3 | Function code |
| req_read | input | 1 | 1 = read, 0 = write |
| req_size | input | 2 | 00 byte, 01 word, 10 long-word |
| req_wdata | input | 32 | Write data |
| rsp_done | output | 1 | Request complete (one cycle) |
| rsp_err | output | 1 | Completion ended by bus error |
| rsp_rdata | output | 32 | Read data, valid with rsp_done |
| bus_addr | output | AW | Bus address |
| bus_fc | output | 3 | Bus function code |
| bus_rw | output | 1 | Direction, 1 = read |
| bus_as | output | 1 | Address strobe, active high |
| bus_uds | output | 1 | Upper data strobe, active high |
| bus_lds | output | 1 | Lower data strobe, active high |
| bus_dout | output | 16 | Write data to the bus |
| bus_doe | output | 1 | Drive enable for bus_dout |
| bus_din | input | 16 | Read data from the bus |
| bus_ack | input | 1 | Asynchronous acknowledge from the slave |
| bus_berr | input | 1 | Asynchronous bus error from the slave |

## Verification
Acknowledge and bus error can both be present when S4 samples them. The block must then take the acknowledge path and report no error. The bench's slave raises both lines on the same clock, with both zero and non-zero delays, so that both values reach S4 together. The cycle-accurate model then expects S7 termination, latched data and `rsp_err` at 0. A second overlap is a bus error on the first word of a long-word, where the error completion must win over the step to the second word. The model checks that S9 ends the request and that no further strobe appears.

// File: rtl/bm_pkg.sv
package bm_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_WORD = 2'b01,
    SZ_LONG = 2'b10
  } size_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_S0, ST_S1, ST_S2, ST_S3, ST_S4, ST_WA, ST_WB,
    ST_S5, ST_S6, ST_S7, ST_E5, ST_E6, ST_E7, ST_E8, ST_E9
  } bus_state_e;

  // {upper, lower} strobe selection
  function automatic logic [1:0] lane_pick(input logic [1:0] sz, input logic a0);
    if (sz == SZ_BYTE) return a0 ? 2'b01 : 2'b10;
    return 2'b11;
  endfunction

  // fold one 16-bit bus beat into the response word
  function automatic logic [31:0] merge_read(input logic [1:0] sz, input logic a0,
                                             input logic second, input logic [15:0] bus,
                                             input logic [31:0] acc);
    case (sz)
      SZ_BYTE: return {24'h0, (a0 ? bus[7:0] : bus[15:8])};
      SZ_LONG: return second ? {acc[31:16], bus} : {bus, acc[15:0]};
      default: return {16'h0, bus};
    endcase
  endfunction

  // 16-bit beat placed on the bus for a write
  function automatic logic [15:0] write_beat(input logic [1:0] sz, input logic second,
                                             input logic [31:0] wd);
    case (sz)
      SZ_BYTE: return {wd[7:0], wd[7:0]};
      SZ_LONG: return second ? wd[15:0] : wd[31:16];
      default: return wd[15:0];
    endcase
  endfunction

endpackage

// File: rtl/bm_sync.sv
module bm_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] pipe [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/bm_seq.sv
module bm_seq
  import bm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       more,
  input  logic       ack_s,
  input  logic       berr_s,
  input  logic       is_write,
  output bus_state_e st,
  output logic       strobe_on,
  output logic       drive_win,
  output logic       ev_latch,
  output logic       ev_next,
  output logic       ev_done,
  output logic       ev_fault
);
  bus_state_e st_nx;

  always_comb begin
    st_nx = st;
    unique case (st)
      ST_IDLE: if (start) st_nx = ST_S0;
      ST_S0:   st_nx = ST_S1;
      ST_S1:   st_nx = ST_S2;
      ST_S2:   st_nx = ST_S3;
      ST_S3:   st_nx = ST_S4;
      ST_S4: begin
        if (ack_s)       st_nx = ST_S5;
        else if (berr_s) st_nx = ST_E5;
        else             st_nx = ST_WA;
      end
      ST_WA:   st_nx = ST_WB;
      ST_WB:   st_nx = ST_S4;
      ST_S5:   st_nx = ST_S6;
      ST_S6:   st_nx = ST_S7;
      ST_S7:   st_nx = more ? ST_S0 : ST_IDLE;
      ST_E5:   st_nx = ST_E6;
      ST_E6:   st_nx = ST_E7;
      ST_E7:   st_nx = ST_E8;
      ST_E8:   st_nx = ST_E9;
      ST_E9:   st_nx = ST_IDLE;
      default: st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= ST_IDLE;
    else        st <= st_nx;
  end

  assign strobe_on = st inside {ST_S2, ST_S3, ST_S4, ST_WA, ST_WB, ST_S5, ST_S6,
                                ST_E5, ST_E6, ST_E7, ST_E8};
  assign drive_win = is_write &&
                     (st inside {ST_S3, ST_S4, ST_WA, ST_WB, ST_S5, ST_S6, ST_S7,
                                 ST_E5, ST_E6, ST_E7, ST_E8});
  assign ev_latch  = (st == ST_S6);
  assign ev_next   = (st == ST_S7) && more;
  assign ev_done   = ((st == ST_S7) && !more) || (st == ST_E9);
  assign ev_fault  = (st == ST_E9);

  assert_strobe_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(strobe_on) |-> $past(st) == ST_S1);
  assert_wait_only_unterminated_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WA) |-> ($past(st) == ST_S4 && !$past(ack_s) && !$past(berr_s)));
  assert_ack_path_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_S5) |-> $past(ack_s));
  assert_fault_path_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_E5) |-> ($past(berr_s) && !$past(ack_s)));
  assert_fault_no_retry_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_E9) |=> (st == ST_IDLE));
endmodule

// File: rtl/bm_path.sv
module bm_path
  import bm_pkg::*;
#(
  parameter int AW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] in_addr,
  input  logic [2:0]    in_fc,
  input  logic          in_read,
  input  logic [1:0]    in_size,
  input  logic [31:0]   in_wdata,
  input  logic          ev_next,
  input  logic          ev_latch,
  input  logic          ev_done,
  input  logic [15:0]   din,
  output logic [AW-1:0] addr_q,
  output logic [2:0]    fc_q,
  output logic          rw_q,
  output logic [1:0]    size_q,
  output logic          more,
  output logic [1:0]    lanes,
  output logic [15:0]   dout,
  output logic [31:0]   rdata_q
);
  localparam logic [AW-1:0] WORD_STEP = AW'(2);

  logic        second_q;
  logic [31:0] wdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q   <= '0;
      fc_q     <= '0;
      rw_q     <= 1'b1;
      size_q   <= SZ_WORD;
      second_q <= 1'b0;
      wdata_q  <= '0;
      rdata_q  <= '0;
    end else begin
      if (load) begin
        addr_q   <= in_addr;
        fc_q     <= in_fc;
        rw_q     <= in_read;
        size_q   <= in_size;
        wdata_q  <= in_wdata;
        second_q <= 1'b0;
        rdata_q  <= '0;
      end else begin
        if (ev_latch) rdata_q <= merge_read(size_q, addr_q[0], second_q, din, rdata_q);
        if (ev_next) begin
          addr_q   <= addr_q + WORD_STEP;
          second_q <= 1'b1;
        end
        if (ev_done) rw_q <= 1'b1;
      end
    end
  end

  assign more  = (size_q == SZ_LONG) && !second_q;
  assign lanes = lane_pick(size_q, addr_q[0]);
  assign dout  = write_beat(size_q, second_q, wdata_q);

  assert_step_two_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_next |=> (addr_q == $past(addr_q) + WORD_STEP));
endmodule

// File: rtl/strobe_bus_master.sv
module strobe_bus_master
  import bm_pkg::*;
#(
  parameter int AW          = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic [2:0]    req_fc,
  input  logic          req_read,
  input  logic [1:0]    req_size,
  input  logic [31:0]   req_wdata,
  output logic          rsp_done,
  output logic          rsp_err,
  output logic [31:0]   rsp_rdata,
  output logic [AW-1:0] bus_addr,
  output logic [2:0]    bus_fc,
  output logic          bus_rw,
  output logic          bus_as,
  output logic          bus_uds,
  output logic          bus_lds,
  output logic [15:0]   bus_dout,
  output logic          bus_doe,
  input  logic [15:0]   bus_din,
  input  logic          bus_ack,
  input  logic          bus_berr
);
  logic [1:0] term_s;
  logic       start;
  logic       more, strobe_on, drive_win;
  logic       ev_latch, ev_next, ev_done, ev_fault;
  logic [1:0] lanes, size_q;
  bus_state_e st;

  bm_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst_n(rst_n), .d({bus_berr, bus_ack}), .q(term_s)
  );

  assign req_ready = (st == ST_IDLE);
  assign start     = req_valid && req_ready;

  bm_seq i_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .more(more),
    .ack_s(term_s[0]), .berr_s(term_s[1]), .is_write(!bus_rw),
    .st(st), .strobe_on(strobe_on), .drive_win(drive_win),
    .ev_latch(ev_latch), .ev_next(ev_next), .ev_done(ev_done), .ev_fault(ev_fault)
  );

  bm_path #(.AW(AW)) i_path (
    .clk(clk), .rst_n(rst_n), .load(start),
    .in_addr(req_addr), .in_fc(req_fc), .in_read(req_read),
    .in_size(req_size), .in_wdata(req_wdata),
    .ev_next(ev_next), .ev_latch(ev_latch), .ev_done(ev_done), .din(bus_din),
    .addr_q(bus_addr), .fc_q(bus_fc), .rw_q(bus_rw), .size_q(size_q),
    .more(more), .lanes(lanes), .dout(bus_dout), .rdata_q(rsp_rdata)
  );

  assign bus_as   = strobe_on;
  assign bus_uds  = strobe_on && lanes[1];
  assign bus_lds  = strobe_on && lanes[0];
  assign bus_doe  = drive_win;
  assign rsp_done = ev_done;
  assign rsp_err  = ev_fault;

  assert_byte_one_lane_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_as && size_q == SZ_BYTE) |-> $countones({bus_uds, bus_lds}) == 1);
  assert_word_both_lanes_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_as && size_q != SZ_BYTE) |-> (bus_uds && bus_lds));
  assert_drive_on_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    bus_doe |-> !bus_rw);
  assert_busy_not_ready_R12: assert property (@(posedge clk) disable iff (!rst_n)
    bus_as |-> !req_ready);
endmodule

// File: tb/test_strobe_bus_master.sv
module test_strobe_bus_master;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_read = 1'b1;
  logic [23:0] req_addr = '0;
  logic [2:0]  req_fc = '0;
  logic [1:0]  req_size = '0;
  logic [31:0] req_wdata = '0;
  logic req_ready, rsp_done, rsp_err, bus_rw, bus_as, bus_uds, bus_lds, bus_doe;
  logic [31:0] rsp_rdata;
  logic [23:0] bus_addr;
  logic [2:0]  bus_fc;
  logic [15:0] bus_dout, bus_din;
  logic bus_ack = 1'b0, bus_berr = 1'b0;

  int checks = 0, errors = 0, cycles = 0;

  // slave behaviour
  int sl_delay = 0, sl_kind = 0, sl_cnt = 0;  // kind 0 ack, 1 ack+berr, 2 berr only
  logic [15:0] sl_hi = '0, sl_lo = '0;
  assign bus_din = bus_addr[1] ? sl_lo : sl_hi;

  strobe_bus_master i_strobe_bus_master (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_fc(req_fc), .req_read(req_read), .req_size(req_size),
    .req_wdata(req_wdata), .rsp_done(rsp_done), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .bus_addr(bus_addr), .bus_fc(bus_fc), .bus_rw(bus_rw), .bus_as(bus_as),
    .bus_uds(bus_uds), .bus_lds(bus_lds), .bus_dout(bus_dout), .bus_doe(bus_doe),
    .bus_din(bus_din), .bus_ack(bus_ack), .bus_berr(bus_berr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (!bus_as) begin
      sl_cnt = 0; bus_ack <= 1'b0; bus_berr <= 1'b0;
    end else begin
      if (sl_cnt >= sl_delay) begin
        bus_ack  <= (sl_kind != 2);
        bus_berr <= (sl_kind != 0);
      end
      sl_cnt++;
    end
  end

  // behavioural reference: m_pos -1 idle, 0..7 normal states, 20/21 wait, 35..39 fault states
  int m_pos = -1, m_word = 0;
  bit m_a1, m_a2, m_b1, m_b2, m_read = 1;
  logic [23:0] m_addr = '0;
  logic [2:0]  m_fc = '0;
  logic [1:0]  m_size = 2'b01;
  logic [31:0] m_wd = '0, m_rd = '0;

  always @(posedge clk) begin
    bit ack_now, berr_now;
    if (!rst_n) begin
      m_pos = -1; m_a1 = 0; m_a2 = 0; m_b1 = 0; m_b2 = 0; m_rd = '0; m_read = 1;
    end else begin
      ack_now = m_a2; berr_now = m_b2;
      m_a2 = m_a1; m_a1 = bus_ack; m_b2 = m_b1; m_b1 = bus_berr;
      case (m_pos)
        -1: if (req_valid) begin
              m_pos = 0; m_word = 0; m_addr = req_addr; m_fc = req_fc;
              m_read = req_read; m_size = req_size; m_wd = req_wdata; m_rd = '0;
            end
        4: m_pos = ack_now ? 5 : (berr_now ? 35 : 20);
        20: m_pos = 21;
        21: m_pos = 4;
        6: begin
             if (m_size == 2'b00) m_rd = {24'h0, (m_addr[0] ? bus_din[7:0] : bus_din[15:8])};
             else if (m_size == 2'b10) begin
               if (m_word == 0) m_rd[31:16] = bus_din; else m_rd[15:0] = bus_din;
             end else m_rd = {16'h0, bus_din};
             m_pos = 7;
           end
        7: if (m_size == 2'b10 && m_word == 0) begin
             m_word = 1; m_addr = m_addr + 24'd2; m_pos = 0;
           end else begin m_pos = -1; m_read = 1; end
        39: begin m_pos = -1; m_read = 1; end
        default: m_pos = m_pos + 1;
      endcase
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual %h expected %h", tag, cycles, act, exp);
    end
  endtask

  // per-cycle comparison
  always @(negedge clk) begin
    bit e_as, e_oe, e_done, e_more;
    logic [15:0] e_dout;
    cycles++;
    if (rst_n) begin
      e_as   = (m_pos inside {2, 3, 4, 5, 6, 20, 21, 35, 36, 37, 38});
      e_oe   = !m_read && (m_pos inside {3, 4, 5, 6, 7, 20, 21, 35, 36, 37, 38});
      e_more = (m_size == 2'b10) && (m_word == 0);
      e_done = (m_pos == 7 && !e_more) || (m_pos == 39);
      if (m_size == 2'b00)      e_dout = {m_wd[7:0], m_wd[7:0]};
      else if (m_size == 2'b10) e_dout = (m_word == 0) ? m_wd[31:16] : m_wd[15:0];
      else                      e_dout = m_wd[15:0];
      chk(req_ready == (m_pos == -1), "R12 ready", 32'(req_ready), 32'(m_pos == -1));
      chk(bus_as == e_as, "R3 address strobe", 32'(bus_as), 32'(e_as));
      chk(bus_uds == (e_as && (m_size != 2'b00 || !m_addr[0])), "R7 R8 upper strobe",
          32'(bus_uds), 32'(e_as && (m_size != 2'b00 || !m_addr[0])));
      chk(bus_lds == (e_as && (m_size != 2'b00 || m_addr[0])), "R7 R8 lower strobe",
          32'(bus_lds), 32'(e_as && (m_size != 2'b00 || m_addr[0])));
      chk(bus_doe == e_oe, "R11 drive enable", 32'(bus_doe), 32'(e_oe));
      chk(bus_rw == m_read, "R2 direction", 32'(bus_rw), 32'(m_read));
      chk(rsp_done == e_done, "R5 R6 done", 32'(rsp_done), 32'(e_done));
      chk(rsp_err == (m_pos == 39), "R6 error flag", 32'(rsp_err), 32'(m_pos == 39));
      if (m_pos != -1) begin
        chk(bus_addr == m_addr, "R2 R9 address", 32'(bus_addr), 32'(m_addr));
        chk(bus_fc == m_fc, "R2 function code", 32'(bus_fc), 32'(m_fc));
      end
      if (e_oe) chk(bus_dout == e_dout, "R7 R9 write beat", 32'(bus_dout), 32'(e_dout));
      if (e_done) chk(rsp_rdata == m_rd, "R5 R7 R9 read data", rsp_rdata, m_rd);
    end
    if (cycles > WATCHDOG) begin
      checks++; errors++;
      $display("FAIL watchdog expired after %0d cycles", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic issue(input logic [23:0] a, input logic [1:0] sz, input bit rd,
                       input logic [31:0] wd, input int dly, input int kind,
                       input logic [15:0] hi, input logic [15:0] lo);
    while (!req_ready) @(negedge clk);
    sl_delay = dly; sl_kind = kind; sl_hi = hi; sl_lo = lo;
    req_addr = a; req_size = sz; req_read = rd; req_wdata = wd; req_fc = a[2:0] ^ 3'b101;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic finish_xfer();
    while (!rsp_done) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic xfer(input logic [23:0] a, input logic [1:0] sz, input bit rd,
                      input logic [31:0] wd, input int dly, input int kind,
                      input logic [15:0] hi, input logic [15:0] lo);
    issue(a, sz, rd, wd, dly, kind, hi, lo);
    finish_xfer();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!bus_as && !bus_uds && !bus_lds, "R1 strobes in reset", {29'h0, bus_as, bus_uds, bus_lds}, 0);
    chk(!bus_doe && !rsp_done && bus_rw && req_ready, "R1 idle outputs in reset",
        {28'h0, bus_doe, rsp_done, bus_rw, req_ready}, 32'h3);
    rst_n = 1'b1;
    @(negedge clk);
    // R7: byte reads on each lane
    xfer(24'h000100, 2'b00, 1, 0, 0, 0, 16'hA1B2, 16'hC3D4);
    xfer(24'h000101, 2'b00, 1, 0, 1, 0, 16'h5566, 16'h7788);
    // R8: word read; R4: long slave delays force wait states
    xfer(24'h000202, 2'b01, 1, 0, 5, 0, 16'h1111, 16'h2345);
    xfer(24'h000300, 2'b01, 1, 0, 11, 0, 16'hBEEF, 16'h0000);
    // R7 R11: byte write to odd address, word write with waits
    xfer(24'h000405, 2'b00, 0, 32'h0000_005A, 2, 0, 0, 0);
    xfer(24'h000406, 2'b01, 0, 32'h0000_CAFE, 7, 0, 0, 0);
    // R9: long-word read and write
    xfer(24'h001000, 2'b10, 1, 0, 0, 0, 16'hDEAD, 16'hF00D);
    xfer(24'h002004, 2'b10, 0, 32'h1234_5678, 4, 0, 0, 0);
    // R5: acknowledge together with bus error takes the normal path
    xfer(24'h003000, 2'b01, 1, 0, 0, 1, 16'h0F0F, 16'h9999);
    xfer(24'h003002, 2'b10, 1, 0, 3, 1, 16'h4242, 16'h2424);
    // R6: bus error alone, on a write so R11 covers the fault path drive window
    xfer(24'h004000, 2'b01, 1, 0, 1, 2, 16'h7777, 16'h7777);
    xfer(24'h004010, 2'b01, 0, 32'h0000_ABCD, 6, 2, 0, 0);
    // R10: bus error on the first word of a long-word
    xfer(24'h005000, 2'b10, 1, 0, 2, 2, 16'h1357, 16'h2468);
    // R12: request held high while busy is ignored
    issue(24'h006000, 2'b01, 1, 0, 6, 0, 16'h6006, 16'h0660);
    req_addr = 24'hFFFFFE; req_size = 2'b00; req_read = 1'b0; req_valid = 1'b1;
    repeat (4) @(negedge clk);
    req_valid = 1'b0;
    finish_xfer();
    xfer(24'h007001, 2'b00, 0, 32'h0000_00C3, 0, 0, 0, 0);
    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule